// File: doc/BRIEF.md
# Edge/Level Interrupt Capture Dispatcher

This block is the capture and dispatch core of an I/O interrupt controller with up to 64 request sources. Every source line is sampled each clock. A per-source trigger-mode bit makes the source either edge-sensitive or level-sensitive. The block keeps a pending bit and an in-service bit for each source and compares each sample against the previous one. When a source is dispatched, it drives one of several upstream interrupt lines, chosen through an 8-bit vector entry for that source.

The surrounding register logic supplies the configuration as plain vectors: trigger modes, the mask and the flattened vector table. It also supplies two strobes. The clear strobe carries a bit pattern. The mask strobe asks the block to re-evaluate sources whose mask bit changed since the previous strobe. The pending and in-service vectors and the upstream lines are registered outputs. Each of them changes on the clock edge that samples the causing event.

Top module: `irq_edge_level_dispatch`

## Requirements
- R1: After a synchronous active-low reset, the pending bits, in-service bits and upstream lines are all 0, and the mask-strobe tracker treats every source as masked.
- R2: An edge-mode source (trigger bit 1) sets its pending bit on a sampled low-to-high change. A later low level leaves the pending bit set.
- R3: A level-mode source (trigger bit 0) has a pending bit equal to its line as sampled at the previous edge.
- R4: Among sources that rose in a cycle, are pending and are unmasked (mask bit 0), only the lowest-numbered one becomes in-service. The upstream line whose index equals its vector entry goes high on the next clock.
- R5: Among sources that fell in a cycle, the lowest-numbered in-service one loses its in-service bit, and the line named by its vector entry goes low.
- R6: A clear strobe affects only the edge-mode bits of its pattern. For those bits it clears pending, drives low the line of the lowest in-service one, and clears their in-service bits. Level-mode bits of the pattern keep their state.
- R7: On a mask strobe, sources unmasked since the last strobe are dispatched as in R4 if pending. Sources masked since the last strobe are released as in R5.
- R8: Sources numbered at or above NUM_SRC never become pending or in-service.
- R9: A vector entry of NUM_OUT or more drives no upstream line, but the source still becomes in-service.
- R10: Events in one cycle are applied in this order: input rises, then input falls, then clear, then mask re-evaluation. At most two sources become in-service per cycle.
- R11: A masked source that rises becomes pending but not in-service and drives no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_lvl_i | input | 64 | Source request lines |
| trig_edge_i | input | 64 | Per-source trigger mode, 1 edge, 0 level |
| src_mask_i | input | 64 | Per-source mask, 1 masked |
| vec_tbl_i | input | 512 | Vector table; entry n at bits [8n+7:8n] |
| clr_stb_i | input | 1 | Software clear strobe |
| clr_bits_i | input | 64 | Bit pattern for the clear strobe |
| mask_eval_i | input | 1 | Mask-change re-evaluation strobe |
| irq_o | output | NUM_OUT | Upstream interrupt lines |
| pend_o | output | 64 | Pending vector |
| isr_o | output | 64 | In-service vector |

## Verification
All state is held in registers, so a wrong pending or in-service bit shows on pend_o or isr_o one clock after the event that caused it. A stale remembered level is different: it stays hidden until the next transition on that source. It then appears as a missing or spurious pending bit and a wrong upstream line in that same cycle. Errors in priority selection or event ordering show on irq_o only when several sources change together, or when a clear or mask strobe coincides with an input change. The stimulus therefore forces those coincidences, and a behavioural model is compared on every clock.

// File: rtl/irqd_pkg.sv
// Shared constants and types for the interrupt capture dispatcher.
// Assumes a fixed maximum of 64 sources and 8-bit vector entries.
package irqd_pkg;
    localparam int MAX_SRC = 64;
    localparam int VEC_W   = 8;
    localparam int SRC_IW  = $clog2(MAX_SRC);
    typedef logic [MAX_SRC-1:0] srcvec_t;
endpackage

// File: rtl/irqd_lowest_pick.sv
// Lowest-index set-bit finder.
// Assumes WIDTH >= 1; idx_o is 0 when no bit is set.
module irqd_lowest_pick #(
    parameter int WIDTH = 64,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] req_i,
    output logic             hit_o,
    output logic [IW-1:0]    idx_o
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        hit_o = |req_i;
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irqd_dispatch_stage.sv
// One dispatch step: picks the lowest candidate source, updates its
// in-service bit and forces the upstream line named by its vector entry.
// DRIVE_HIGH=1 builds an assert step (candidates = affected & eligible).
// DRIVE_HIGH=0 builds a release step (candidates = affected & in-service).
// Assumes NUM_OUT <= 256 so an 8-bit entry can name every line.
module irqd_dispatch_stage
    import irqd_pkg::*;
#(
    parameter int NUM_OUT    = 16,
    parameter bit DRIVE_HIGH = 1'b1
) (
    input  srcvec_t                    affect_i,
    input  srcvec_t                    elig_i,
    input  srcvec_t                    isr_i,
    input  logic [NUM_OUT-1:0]         line_i,
    input  logic [MAX_SRC*VEC_W-1:0]   vec_tbl_i,
    output srcvec_t                    isr_o,
    output logic [NUM_OUT-1:0]         line_o
);
    localparam int OW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

    srcvec_t            cand;
    srcvec_t            onehot;
    logic               hit;
    logic [SRC_IW-1:0]  idx;
    logic [VEC_W-1:0]   vsel;

    assign cand = affect_i & (DRIVE_HIGH ? elig_i : isr_i);

    irqd_lowest_pick #(.WIDTH(MAX_SRC)) u_pick (
        .req_i (cand),
        .hit_o (hit),
        .idx_o (idx)
    );

    assign vsel   = vec_tbl_i[idx*VEC_W +: VEC_W];
    assign onehot = hit ? (srcvec_t'(1) << idx) : '0;

    generate
        if (DRIVE_HIGH) begin : g_set
            assign isr_o = isr_i | onehot;
        end else begin : g_clr
            assign isr_o = isr_i & ~onehot;
        end
    endgenerate

    // Force the selected upstream line when the entry is in range.
    always_comb begin
        line_o = line_i;
        if (hit && (int'(vsel) < NUM_OUT)) line_o[vsel[OW-1:0]] = DRIVE_HIGH;
    end
endmodule

// File: rtl/irqd_src_capture.sv
// Per-source capture: remembers the previous level, forms rise/fall
// events and computes pending after inputs and after the clear.
// Assumes clr_bits_i is already gated by the clear strobe.
module irqd_src_capture
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic    clk,
    input  logic    rst_n,
    input  srcvec_t lvl_i,
    input  srcvec_t edge_sel_i,
    input  srcvec_t clr_bits_i,
    output srcvec_t rise_o,
    output srcvec_t fall_o,
    output srcvec_t pend_in_o,
    output srcvec_t pend_nx_o,
    output srcvec_t pend_q_o
);
    localparam srcvec_t IMPL = srcvec_t'({MAX_SRC{1'b1}} >> (MAX_SRC - NUM_SRC));

    srcvec_t last_q;
    srcvec_t pend_q;

    assign rise_o    = lvl_i & ~last_q & IMPL;
    assign fall_o    = ~lvl_i & last_q & IMPL;
    assign pend_in_o = ((edge_sel_i & (pend_q | rise_o)) | (~edge_sel_i & lvl_i)) & IMPL;
    assign pend_nx_o = pend_in_o & ~(clr_bits_i & edge_sel_i);
    assign pend_q_o  = pend_q;

    // Hold remembered level and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            pend_q <= '0;
        end else begin
            last_q <= lvl_i & IMPL;
            pend_q <= pend_nx_o;
        end
    end
endmodule

// File: rtl/irq_edge_level_dispatch.sv
// Top of the interrupt capture dispatcher. Chains five dispatch steps in
// fixed order: input assert, input release, clear release, unmask assert,
// mask release. In-service bits of cleared sources are wiped between the
// clear step and the unmask step. Outputs are registered.
// Assumes 1 <= NUM_SRC <= 64 and 1 <= NUM_OUT <= 256.
module irq_edge_level_dispatch
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_OUT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [MAX_SRC-1:0]         src_lvl_i,
    input  logic [MAX_SRC-1:0]         trig_edge_i,
    input  logic [MAX_SRC-1:0]         src_mask_i,
    input  logic [MAX_SRC*VEC_W-1:0]   vec_tbl_i,
    input  logic                       clr_stb_i,
    input  logic [MAX_SRC-1:0]         clr_bits_i,
    input  logic                       mask_eval_i,
    output logic [NUM_OUT-1:0]         irq_o,
    output logic [MAX_SRC-1:0]         pend_o,
    output logic [MAX_SRC-1:0]         isr_o
);
    localparam srcvec_t IMPL      = srcvec_t'({MAX_SRC{1'b1}} >> (MAX_SRC - NUM_SRC));
    localparam int      NSTAGE    = 5;
    localparam int      CLR_STAGE = 2;
    localparam logic [NSTAGE-1:0] STAGE_SET = 5'b01001;

    srcvec_t isr_q;
    srcvec_t mseen_q;
    logic [NUM_OUT-1:0] irq_q;

    srcvec_t clr_eff, rise, fall, pend_in, pend_nx, pend_q;
    srcvec_t unmask_set, newmask_set;

    srcvec_t            st_aff     [NSTAGE];
    srcvec_t            st_elig    [NSTAGE];
    srcvec_t            st_isr_in  [NSTAGE];
    srcvec_t            st_isr_out [NSTAGE];
    logic [NUM_OUT-1:0] st_line_in [NSTAGE];
    logic [NUM_OUT-1:0] st_line_out[NSTAGE];

    assign clr_eff     = clr_stb_i   ? (clr_bits_i & trig_edge_i & IMPL) : '0;
    assign unmask_set  = mask_eval_i ? (mseen_q & ~src_mask_i & IMPL)    : '0;
    assign newmask_set = mask_eval_i ? (~mseen_q & src_mask_i & IMPL)    : '0;

    irqd_src_capture #(.NUM_SRC(NUM_SRC)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (src_lvl_i),
        .edge_sel_i (trig_edge_i),
        .clr_bits_i (clr_eff),
        .rise_o     (rise),
        .fall_o     (fall),
        .pend_in_o  (pend_in),
        .pend_nx_o  (pend_nx),
        .pend_q_o   (pend_q)
    );

    // Select affected and eligible sets for each step in order.
    always_comb begin
        st_aff[0]  = rise;        st_elig[0] = pend_in & ~src_mask_i;
        st_aff[1]  = fall;        st_elig[1] = '0;
        st_aff[2]  = clr_eff;     st_elig[2] = '0;
        st_aff[3]  = unmask_set;  st_elig[3] = pend_nx & ~src_mask_i;
        st_aff[4]  = newmask_set; st_elig[4] = '0;
    end

    generate
        for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
            if (k == 0) begin : g_first
                assign st_isr_in[k]  = isr_q;
                assign st_line_in[k] = irq_q;
            end else if (k == CLR_STAGE + 1) begin : g_wipe
                assign st_isr_in[k]  = st_isr_out[k-1] & ~clr_eff;
                assign st_line_in[k] = st_line_out[k-1];
            end else begin : g_chain
                assign st_isr_in[k]  = st_isr_out[k-1];
                assign st_line_in[k] = st_line_out[k-1];
            end

            irqd_dispatch_stage #(
                .NUM_OUT    (NUM_OUT),
                .DRIVE_HIGH (STAGE_SET[k])
            ) u_step (
                .affect_i  (st_aff[k]),
                .elig_i    (st_elig[k]),
                .isr_i     (st_isr_in[k]),
                .line_i    (st_line_in[k]),
                .vec_tbl_i (vec_tbl_i),
                .isr_o     (st_isr_out[k]),
                .line_o    (st_line_out[k])
            );
        end
    endgenerate

    // Register in-service state, upstream lines and the mask tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q   <= '0;
            irq_q   <= '0;
            mseen_q <= '1;
        end else begin
            isr_q   <= st_isr_out[NSTAGE-1];
            irq_q   <= st_line_out[NSTAGE-1];
            if (mask_eval_i) mseen_q <= src_mask_i;
        end
    end

    assign irq_o  = irq_q;
    assign pend_o = pend_q;
    assign isr_o  = isr_q;
endmodule

// File: rtl/irqd_checker.sv
// Property checker for irq_edge_level_dispatch, attached by bind.
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [63:0]   src_lvl_i,
    input logic [63:0]   trig_edge_i,
    input logic [63:0]   src_mask_i,
    input logic          clr_stb_i,
    input logic [63:0]   clr_bits_i,
    input logic [63:0]   pend_o,
    input logic [63:0]   isr_o
);
    localparam srcvec_t IMPL = srcvec_t'({MAX_SRC{1'b1}} >> (MAX_SRC - NUM_SRC));

    p_impl_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o | isr_o) & ~IMPL) == '0);

    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_o & trig_edge_i & ~(clr_stb_i ? clr_bits_i : 64'd0)) & ~pend_o) == '0));

    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(trig_edge_i)) == ($past(src_lvl_i & ~trig_edge_i) & IMPL)));

    p_new_isr_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((isr_o & ~$past(isr_o) & ~pend_o) == '0));

    p_new_isr_unmasked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((isr_o & ~$past(isr_o) & $past(src_mask_i)) == '0));

    p_two_new_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(isr_o & ~$past(isr_o)) <= 2));

    p_clear_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb_i |=> (((isr_o | pend_o) & $past(clr_bits_i & trig_edge_i)) == '0));
endmodule

bind irq_edge_level_dispatch irqd_checker #(.NUM_SRC(NUM_SRC)) u_irqd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_lvl_i   (src_lvl_i),
    .trig_edge_i (trig_edge_i),
    .src_mask_i  (src_mask_i),
    .clr_stb_i   (clr_stb_i),
    .clr_bits_i  (clr_bits_i),
    .pend_o      (pend_o),
    .isr_o       (isr_o)
);

// File: tb/irq_edge_level_dispatch_bench.sv
module irq_edge_level_dispatch_bench;
    localparam int NSRC = 40;
    localparam int NOUT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [63:0] src = '0, edg = '0, msk = '1, clr_pat = '0;
    logic clr_stb = 1'b0, meval = 1'b0;
    logic [7:0] vtab [64];
    logic [511:0] vbus;
    logic [NOUT-1:0] irq;
    logic [63:0] pend, isr;

    logic [63:0] m_pend, m_isr, m_last, m_mseen;
    logic [NOUT-1:0] m_irq;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always_comb for (int i = 0; i < 64; i++) vbus[i*8 +: 8] = vtab[i];

    irq_edge_level_dispatch #(.NUM_SRC(NSRC), .NUM_OUT(NOUT)) u_irq_edge_level_dispatch (
        .clk(clk), .rst_n(rst_n), .src_lvl_i(src), .trig_edge_i(edg),
        .src_mask_i(msk), .vec_tbl_i(vbus), .clr_stb_i(clr_stb),
        .clr_bits_i(clr_pat), .mask_eval_i(meval),
        .irq_o(irq), .pend_o(pend), .isr_o(isr)
    );

    function automatic int lowest(input logic [63:0] v);
        for (int i = 0; i < 64; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic put_line(input int s, input bit v);
        if (s >= 0 && int'(vtab[s]) < NOUT) m_irq[int'(vtab[s])] = v;
    endtask

    // Behavioural reference: one clock of the requirement rules.
    task automatic model_step();
        logic [63:0] impl, rise, fall, c, u, d;
        int k;
        impl = (64'd1 << NSRC) - 64'd1;
        rise = src & ~m_last & impl;
        fall = ~src & m_last & impl;
        for (int i = 0; i < 64; i++)
            if (impl[i]) m_pend[i] = edg[i] ? (m_pend[i] | rise[i]) : src[i];
        m_last = src & impl;
        k = lowest(rise & m_pend & ~msk);
        if (k >= 0) begin m_isr[k] = 1'b1; put_line(k, 1'b1); end
        k = lowest(fall & m_isr);
        if (k >= 0) begin m_isr[k] = 1'b0; put_line(k, 1'b0); end
        if (clr_stb) begin
            c = clr_pat & edg & impl;
            m_pend &= ~c;
            k = lowest(c & m_isr);
            put_line(k, 1'b0);
            m_isr &= ~c;
        end
        if (meval) begin
            u = m_mseen & ~msk & impl;
            d = ~m_mseen & msk & impl;
            k = lowest(u & m_pend & ~msk);
            if (k >= 0) begin m_isr[k] = 1'b1; put_line(k, 1'b1); end
            k = lowest(d & m_isr);
            if (k >= 0) begin m_isr[k] = 1'b0; put_line(k, 1'b0); end
            m_mseen = msk;
        end
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance one clock, then compare all outputs against the model.
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        #1;
        check({tag, " pend"}, pend, m_pend);
        check({tag, " isr"}, isr, m_isr);
        check({tag, " irq"}, 64'(irq), 64'(m_irq));
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) vtab[i] = 8'(i % 16);
        vtab[20] = 8'd200;
        edg = 64'h0000_0000_0000_FFFF;
        m_pend = '0; m_isr = '0; m_last = '0; m_mseen = '1; m_irq = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pend", pend, 64'd0);
        check("R1 reset isr", isr, 64'd0);
        check("R1 reset irq", 64'(irq), 64'd0);
        rst_n = 1'b1;

        src[25] = 1'b1; tick("R11");
        check("R11 masked pend", 64'(pend[25]), 64'd1);
        check("R11 masked isr", 64'(isr[25]), 64'd0);

        msk = '0; meval = 1'b1; tick("R7"); meval = 1'b0;
        check("R7 R1 unmask isr", 64'(isr[25]), 64'd1);
        check("R7 unmask irq9", 64'(irq[9]), 64'd1);

        src[25] = 1'b0; tick("R5");
        check("R3 level follow", 64'(pend[25]), 64'd0);
        check("R5 release irq9", 64'(irq[9]), 64'd0);

        src[2] = 1'b1; tick("R2");
        check("R2 edge irq2", 64'(irq[2]), 64'd1);
        src[2] = 1'b0; tick("R2");
        check("R2 edge pend kept", 64'(pend[2]), 64'd1);
        check("R5 edge isr drop", 64'(isr[2]), 64'd0);

        src[20] = 1'b1; tick("R9");
        check("R9 isr set", 64'(isr[20]), 64'd1);
        check("R9 no line", 64'(irq), 64'd0);

        clr_stb = 1'b1; clr_pat = (64'd1 << 2) | (64'd1 << 20); tick("R6");
        clr_stb = 1'b0; clr_pat = '0;
        check("R6 edge cleared", 64'(pend[2]), 64'd0);
        check("R6 level kept", 64'({pend[20], isr[20]}), 64'd3);

        src[6] = 1'b1; src[4] = 1'b1; tick("R4");
        check("R4 lowest isr", isr & 64'h50, 64'h10);
        check("R4 lines", 64'({irq[6], irq[4]}), 64'd1);

        src[50] = 1'b1; tick("R8");
        check("R8 ignored", 64'({pend[50], isr[50]}), 64'd0);

        src[8] = 1'b1; clr_stb = 1'b1; clr_pat = 64'd1 << 8; tick("R10");
        clr_stb = 1'b0; clr_pat = '0;
        check("R10 order", 64'({pend[8], isr[8], irq[8]}), 64'd0);

        msk[4] = 1'b1; meval = 1'b1; tick("R7"); meval = 1'b0;
        check("R7 mask release", 64'({isr[4], irq[4]}), 64'd0);

        for (int n = 0; n < 600; n++) begin
            src     = src ^ (64'($urandom) & 64'h0000_FFFF_0000_0000 >> 16) ^ (64'($urandom_range(0, 3)) << $urandom_range(0, 47));
            clr_stb = ($urandom_range(0, 7) == 0);
            clr_pat = {32'($urandom), 32'($urandom)};
            meval   = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 9) == 0) msk = {32'($urandom), 32'($urandom)};
            if ($urandom_range(0, 19) == 0) vtab[$urandom_range(0, 39)] = 8'($urandom_range(0, 19));
            tick("R10 mixed");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule